// File: doc/BRIEF.md
# Hardware Event Flag Unit

This block keeps one single-bit flag for every hardware event source in a chip, such as frame-start, frame-end and underrun pulses from display pipelines. A pulse on a source line raises its flag, and the flag stays raised until a command thread changes it. Command threads use the unit to wait on an event and to clear events. Each thread presents an event number and a 32-bit option word. The option word asks the unit to wait until the flag holds a given value, to write a new value into the flag, or both.

The unit answers each request with a single-cycle grant once the wait condition holds. The flag update is applied at the same clock edge that registers the grant, so no other thread can see the flag between the test and the write. A frame-synchronised thread can therefore block on "frame start, then clear" as one indivisible step. A plain clear is the same operation with the wait disabled. It never blocks.

Each cycle the unit serves at most one request. Among the threads that can proceed, the lowest-numbered thread is served. An event number beyond the implemented range is answered with a reject pulse instead of a grant. Decoding of the thread instructions is left to the threads.

Top module: `event_flag_unit`

## Requirements
- R1: After a synchronous reset every flag reads 0, and no grant or reject is asserted until a request is served.
- R2: The option word fields sit at fixed positions: bit 15 enables the wait, and bit 0 of bits 11:0 is the awaited flag value; bit 31 enables the update, and bit 0 of bits 27:16 is the value written. All other option bits are ignored.
- R3: A request with the wait enabled blocks while the flag differs from the awaited value. It is granted one cycle after the first cycle in which the flag matches.
- R4: A wait with update (wait 1, write 0) is atomic. The flag is cleared at the same edge that registers the grant, so a later probe finds it at 0.
- R5: A request with the wait disabled and the update enabled is granted in the cycle after it is presented, whatever the flag value. The update value is written to the flag.
- R6: A request with the update disabled leaves the flag unchanged. A flag changes only through a source pulse or a served update.
- R7: A one-cycle source pulse sets its flag to 1, and the flag holds 1 for any number of idle cycles until an update changes it.
- R8: A source pulse in the same cycle as a served update to the same flag wins, and the flag ends at 1.
- R9: A request whose event number is 260 or more gets a reject pulse one cycle later, and no flag is changed. Event numbers 0 to 259 are valid.
- R10: When several threads can proceed in the same cycle, only the lowest-numbered one is served, and the others are considered again in later cycles. Between two threads waiting to clear the same flag, the lower one consumes the flag.
- R11: A request is not considered in the cycle in which its own grant or reject is asserted, so one request held one cycle late is served only once.
- R12: An update with update value bit 0 equal to 1 sets the flag to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | N_EVENTS | One pulse line per event source; a high cycle sets the flag |
| thr_req | input | N_THREADS | Request valid per thread, held until grant or reject |
| thr_id | input | N_THREADS*ID_W | Event number per thread, thread t in bits t*ID_W upward |
| thr_opt | input | N_THREADS*32 | Option word per thread, thread t in bits t*32 upward |
| thr_gnt | output | N_THREADS | Registered one-cycle grant per thread |
| thr_rej | output | N_THREADS | Registered one-cycle reject per thread for an out-of-range event |

## Verification
The assertions assume that a thread holds its event number and option word steady while its request is pending. They also assume it drops the request no later than one cycle after its grant or reject, and that source pulses stay low during reset. The stimulus follows these rules. Each thread's request line is released by a bench process that watches that thread's own grant and reject. One thread is deliberately made one cycle late, which is the worst case the unit must tolerate. Pulses are driven only after reset has been released, and always as single-cycle strobes.

// File: rtl/evflag_pkg.sv
package evflag_pkg;
  // option word layout; the positions are part of the thread-facing contract
  localparam int OPT_W        = 32;
  localparam int WAIT_VAL_LSB = 0;
  localparam int WAIT_EN_BIT  = 15;
  localparam int UPD_VAL_LSB  = 16;
  localparam int UPD_EN_BIT   = 31;

  typedef struct packed {
    logic wait_en;
    logic wait_bit;
    logic upd_en;
    logic upd_bit;
  } evf_op_t;
endpackage

// File: rtl/evflag_pick.sv
module evflag_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] win,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  // fixed priority: index 0 is the most urgent
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win[i]    = cand[i] & ~seen[i];
    assign seen[i+1] = seen[i] | cand[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/evflag_elig.sv
module evflag_elig
  import evflag_pkg::*;
#(
  parameter int N_EVENTS  = 260,
  parameter int N_THREADS = 4,
  parameter int ID_W      = 9
) (
  input  logic [N_EVENTS-1:0]        flags,
  input  logic [N_THREADS-1:0]       req,
  input  logic [N_THREADS-1:0]       busy,
  input  logic [N_THREADS*ID_W-1:0]  id_flat,
  input  logic [N_THREADS*OPT_W-1:0] opt_flat,
  output logic [N_THREADS-1:0]       elig,
  output logic [N_THREADS-1:0]       oor,
  output evf_op_t [N_THREADS-1:0]    ops
);
  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    logic [ID_W-1:0]  id_t;
    logic [OPT_W-1:0] w;
    logic             flag_t;
    logic             match;
    logic             unused_w;

    assign id_t     = id_flat[t*ID_W +: ID_W];
    assign w        = opt_flat[t*OPT_W +: OPT_W];
    assign unused_w = ^w;
    assign oor[t]   = (32'(id_t) >= 32'(N_EVENTS));
    assign flag_t   = oor[t] ? 1'b0 : flags[id_t];
    assign match    = ~w[WAIT_EN_BIT] | (flag_t == w[WAIT_VAL_LSB]);
    assign elig[t]  = req[t] & ~busy[t] & (oor[t] | match);

    assign ops[t].wait_en  = w[WAIT_EN_BIT];
    assign ops[t].wait_bit = w[WAIT_VAL_LSB];
    assign ops[t].upd_en   = w[UPD_EN_BIT];
    assign ops[t].upd_bit  = w[UPD_VAL_LSB];
  end
endmodule

// File: rtl/evflag_bank.sv
module evflag_bank #(
  parameter int N_EVENTS = 260,
  parameter int ID_W     = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_EVENTS-1:0] set_pulse,
  input  logic                upd_strobe,
  input  logic [ID_W-1:0]     upd_idx,
  input  logic                upd_bit,
  output logic [N_EVENTS-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      for (int e = 0; e < N_EVENTS; e++) begin
        if (set_pulse[e])
          flags[e] <= 1'b1;
        else if (upd_strobe && (32'(upd_idx) == e))
          flags[e] <= upd_bit;
      end
    end
  end

  // R8
  pulse_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_pulse) |=> ((flags & $past(set_pulse)) == $past(set_pulse)));

  // R6
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|set_pulse) && !upd_strobe) |=> $stable(flags));
endmodule

// File: rtl/event_flag_unit.sv
module event_flag_unit
  import evflag_pkg::*;
#(
  parameter int N_EVENTS  = 260,
  parameter int N_THREADS = 4,
  parameter int ID_W      = $clog2(N_EVENTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_EVENTS-1:0]        evt_pulse,
  input  logic [N_THREADS-1:0]       thr_req,
  input  logic [N_THREADS*ID_W-1:0]  thr_id,
  input  logic [N_THREADS*OPT_W-1:0] thr_opt,
  output logic [N_THREADS-1:0]       thr_gnt,
  output logic [N_THREADS-1:0]       thr_rej
);
  logic [N_EVENTS-1:0]     flags;
  logic [N_THREADS-1:0]    gnt_q, rej_q, busy, elig, oor, win;
  evf_op_t [N_THREADS-1:0] ops;
  logic                    any;
  logic [ID_W-1:0]         sel_id;
  evf_op_t                 sel_op;
  logic                    sel_oor;
  logic                    upd_strobe;

  assign busy = gnt_q | rej_q;

  evflag_elig #(
    .N_EVENTS (N_EVENTS),
    .N_THREADS(N_THREADS),
    .ID_W     (ID_W)
  ) u_elig (
    .flags   (flags),
    .req     (thr_req),
    .busy    (busy),
    .id_flat (thr_id),
    .opt_flat(thr_opt),
    .elig    (elig),
    .oor     (oor),
    .ops     (ops)
  );

  evflag_pick #(.N(N_THREADS)) u_pick (
    .cand(elig),
    .win (win),
    .any (any)
  );

  // one-hot OR mux of the served request
  always_comb begin
    sel_id  = '0;
    sel_op  = '0;
    sel_oor = 1'b0;
    for (int t = 0; t < N_THREADS; t++) begin
      if (win[t]) begin
        sel_id  = sel_id | thr_id[t*ID_W +: ID_W];
        sel_op  = sel_op | ops[t];
        sel_oor = sel_oor | oor[t];
      end
    end
  end

  assign upd_strobe = any & ~sel_oor & sel_op.upd_en;

  evflag_bank #(
    .N_EVENTS(N_EVENTS),
    .ID_W    (ID_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (evt_pulse),
    .upd_strobe(upd_strobe),
    .upd_idx   (sel_id),
    .upd_bit   (sel_op.upd_bit),
    .flags     (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
      rej_q <= '0;
    end else begin
      gnt_q <= win & ~oor;
      rej_q <= win & oor;
    end
  end

  assign thr_gnt = gnt_q;
  assign thr_rej = rej_q;

  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_q, rej_q}));

  for (genvar t = 0; t < N_THREADS; t++) begin : g_chk
    // R9
    rej_range_chk: assert property (@(posedge clk) disable iff (rst)
      rej_q[t] |-> (32'($past(thr_id[t*ID_W +: ID_W])) >= 32'(N_EVENTS)));
    // R9
    gnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_q[t] |-> ($past(thr_req[t]) &&
                    (32'($past(thr_id[t*ID_W +: ID_W])) < 32'(N_EVENTS))));
    // R11
    no_double_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt_q[t] || rej_q[t]) |=> !(gnt_q[t] || rej_q[t]));
  end
endmodule

// File: tb/event_flag_unit_test.sv
module event_flag_unit_test;
  localparam int NE = 260;
  localparam int NT = 4;
  localparam int IW = $clog2(NE);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NE-1:0]    evt = '0;
  logic [NT-1:0]    req = '0;
  logic [NT*IW-1:0] id  = '0;
  logic [NT*32-1:0] opt = '0;
  logic [NT-1:0]    gnt, rej;
  logic [NT-1:0]    late = '0;
  logic [NT-1:0]    hold = '0;
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int    cyc;
    int    thr;
    bit    rej;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  event_flag_unit #(.N_EVENTS(NE), .N_THREADS(NT)) uut (
    .clk(clk), .rst(rst), .evt_pulse(evt), .thr_req(req),
    .thr_id(id), .thr_opt(opt), .thr_gnt(gnt), .thr_rej(rej)
  );

  // option word: [31] update enable, [27:16] update value, [15] wait enable, [11:0] wait value
  function automatic logic [31:0] mk(bit we, int wv, bit ue, int uv);
    return {ue, 3'b000, 12'(uv), we, 3'b000, 12'(wv)};
  endfunction

  task automatic issue(int t, int i, logic [31:0] o);
    id[t*IW +: IW] = IW'(i);
    opt[t*32 +: 32] = o;
    req[t] = 1'b1;
  endtask

  task automatic exp_ev(int c, int t, bit r, string tag);
    exp_t e;
    e.cyc = c; e.thr = t; e.rej = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares observed answers against the queue; also releases requests
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        checks++; fails++;
        $display("FAIL %s: thread %0d answer missing, actual none at cycle %0d, expected cycle %0d",
                 q[0].tag, q[0].thr, cyc, q[0].cyc);
        void'(q.pop_front());
      end
      for (int t = 0; t < NT; t++) begin
        if (gnt[t] || rej[t]) begin
          checks++;
          if (q.size() == 0 || q[0].cyc != cyc || q[0].thr != t || q[0].rej != rej[t]) begin
            fails++;
            if (q.size() == 0)
              $display("FAIL unexpected: thread %0d rej=%0d at cycle %0d, expected no answer",
                       t, rej[t], cyc);
            else
              $display("FAIL %s: actual thread %0d rej=%0d cycle %0d, expected thread %0d rej=%0d cycle %0d",
                       q[0].tag, t, rej[t], cyc, q[0].thr, q[0].rej, q[0].cyc);
          end else begin
            void'(q.pop_front());
          end
        end
        if (hold[t]) begin
          req[t] <= 1'b0;
          hold[t] <= 1'b0;
        end else if (gnt[t] || rej[t]) begin
          if (late[t]) hold[t] <= 1'b1;
          else req[t] <= 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c;
    step(5);
    rst = 1'b0;
    step(1);
    // R1: quiet outputs after reset
    checks++;
    if (gnt !== '0 || rej !== '0) begin
      fails++;
      $display("FAIL R1: gnt=%b rej=%b, expected 0000 0000", gnt, rej);
    end
    // R1: flag 20 reads 0 (wait for value 0 passes at once)
    c = cyc; exp_ev(c + 1, 0, 0, "R1"); issue(0, 20, mk(1, 0, 0, 0)); step(3);

    // R3: wait-and-clear blocks until a pulse arrives
    issue(1, 11, mk(1, 1, 1, 0)); step(4);
    c = cyc; exp_ev(c + 2, 1, 0, "R3");
    evt[11] = 1'b1; step(1); evt[11] = 1'b0; step(3);
    // R4: the flag was cleared by the served wait
    c = cyc; exp_ev(c + 1, 0, 0, "R4"); issue(0, 11, mk(1, 0, 0, 0)); step(3);

    // R7: pulse holds; R2: only bit 0 of the wait value counts
    evt[40] = 1'b1; step(1); evt[40] = 1'b0; step(6);
    c = cyc; exp_ev(c + 1, 2, 0, "R7"); issue(2, 40, mk(1, 12'h003, 0, 0)); step(3);
    // R6: a wait without update left it at 1
    c = cyc; exp_ev(c + 1, 2, 0, "R6"); issue(2, 40, mk(1, 1, 0, 0)); step(3);

    // R5: clear-only, then probe 0, then clear-only on a flag already 0
    c = cyc; exp_ev(c + 1, 0, 0, "R5"); issue(0, 40, mk(0, 0, 1, 0)); step(3);
    c = cyc; exp_ev(c + 1, 0, 0, "R5"); issue(0, 40, mk(1, 0, 0, 0)); step(3);
    c = cyc; exp_ev(c + 1, 0, 0, "R5"); issue(0, 40, mk(0, 0, 1, 0)); step(3);

    // R12: update value 1 sets the top flag
    c = cyc; exp_ev(c + 1, 3, 0, "R12"); issue(3, 259, mk(0, 0, 1, 1)); step(3);
    c = cyc; exp_ev(c + 1, 3, 0, "R12"); issue(3, 259, mk(1, 1, 0, 0)); step(3);

    // R9: out-of-range numbers are rejected and change nothing
    c = cyc; exp_ev(c + 1, 1, 1, "R9"); issue(1, 260, mk(0, 0, 1, 0)); step(3);
    c = cyc; exp_ev(c + 1, 1, 1, "R9"); issue(1, 511, mk(1, 1, 1, 0)); step(3);
    c = cyc; exp_ev(c + 1, 3, 0, "R9"); issue(3, 259, mk(1, 1, 0, 0)); step(3);

    // R8: pulse and clear of flag 63 in the same cycle
    c = cyc; exp_ev(c + 1, 0, 0, "R8"); issue(0, 63, mk(0, 0, 1, 0));
    evt[63] = 1'b1; step(1); evt[63] = 1'b0; step(3);
    c = cyc; exp_ev(c + 1, 0, 0, "R8"); issue(0, 63, mk(1, 1, 0, 0)); step(3);

    // R10: two waiters on flag 14, lower thread consumes it
    evt[14] = 1'b1; step(1); evt[14] = 1'b0; step(3);
    c = cyc; exp_ev(c + 1, 1, 0, "R10");
    issue(2, 14, mk(1, 1, 1, 0)); issue(1, 14, mk(1, 1, 1, 0)); step(4);
    c = cyc; exp_ev(c + 2, 2, 0, "R10");
    evt[14] = 1'b1; step(1); evt[14] = 1'b0; step(3);
    // R10: two clears in one cycle are served one after the other
    c = cyc; exp_ev(c + 1, 0, 0, "R10"); exp_ev(c + 2, 3, 0, "R10");
    issue(3, 30, mk(0, 0, 1, 0)); issue(0, 31, mk(0, 0, 1, 0)); step(4);

    // R11: request released one cycle late is served once
    late[3] = 1'b1;
    c = cyc; exp_ev(c + 1, 3, 0, "R11"); issue(3, 30, mk(0, 0, 1, 0)); step(6);
    late[3] = 1'b0;

    step(4);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d answers outstanding, expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule